// File: doc/BRIEF.md
# Wormhole Switch Allocator for a Five-Port Mesh Router

This block decides, once per clock, which input of a five-port mesh router may forward its front flit to each output. The five ports are indexed HOME=0, UP=1, DOWN=2, LEFT=3 and RIGHT=4, and the same index names an input and an output. Each input reports whether it holds a flit, the flit's kind, and the destination coordinates carried by that flit. Routing is dimension ordered. The block moves a packet along X until the column matches, then along Y, and hands it to HOME when both coordinates match.

Each output arbitrates among the head flits routed to it. It uses a rotating priority that begins one position past the input it last served. When packets span several flits, the winning input owns the output until its tail flit has gone through. Body and tail flits follow without arbitration. An output takes part only when the credit count reported for it allows. One parameter picks the network variant: a request network keeps one HOME slot in reserve, and a response network's HOME output is never held back by credit. The grants come out of registers as one one-hot vector per output, and the surrounding datapath uses them to steer the crossbar one cycle later.

Top module: `wh_switch_alloc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every grant bit is 0 and every output is unlocked. Each output's priority pointer starts at input 4, so its first search tries input 0 first.
- R2: A flit whose destination X is below `here_x` is routed to LEFT (3). One whose destination X is above `here_x` is routed to RIGHT (4).
- R3: When the destination X equals `here_x`, a destination Y below `here_y` routes to UP (1) and one above routes to DOWN (2). When both coordinates match, the flit routes to HOME (0).
- R4: An unlocked, eligible output grants the first requesting input found in the order pointer+1, pointer+2, and so on, wrapping modulo 5. The pointer then moves to the granted input.
- R5: An unlocked output accepts only flits of kind head (code 0) as requests. Flits of kind body (1), tail (2) or code 3 are ignored.
- R6: With `MULTI_FLIT`=1, a grant locks the output to the granted input. While locked, the owner's valid flit is granted whatever its kind or coordinates, other inputs are not granted, and the pointer moves to the owner. An input that owns a locked output does not request any other output.
- R7: A locked output that forwards a tail flit (code 2) from its owner becomes unlocked and arbitrates again on the next cycle.
- R8: An output whose credit count is too low for it to be eligible grants nothing and keeps its lock, owner and pointer.
- R9: Outputs 1 to 4 are eligible with a credit of at least 1. HOME is eligible with at least 2 credits in a request network (`NET_KIND`=1), is always eligible in a response network (`NET_KIND`=2), and needs at least 1 credit otherwise.
- R10: With `MULTI_FLIT`=0, an output never locks, and every head flit arbitrates on its own.
- R11: A locked output whose owner presents no valid flit grants nothing and stays locked to the same owner.
- R12: A grant appears on `grant` one cycle after the inputs that produced it. Each output's 5-bit slice is zero or one-hot, and no input is granted by more than one output in a cycle.
- R13: An unlocked output with no eligible requester grants nothing and keeps its pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| here_x | input | COORD_W | X coordinate of this router |
| here_y | input | COORD_W | Y coordinate of this router |
| in_valid | input | 5 | Input i holds a flit at its front |
| in_type | input | 10 | Flit kind of input i in bits [2i+1:2i]: 0 head, 1 body, 2 tail, 3 treated as body |
| in_dst_x | input | 5*COORD_W | Destination X of input i in slice i |
| in_dst_y | input | 5*COORD_W | Destination Y of input i in slice i |
| out_credit | input | 5*CREDIT_W | Credit count of output o in slice o |
| grant | output | 25 | Bit 5*o+i: output o forwards the flit of input i |

## Verification
The bench builds two copies with 2-bit coordinates and 2-bit credit counts, and places the router at (1,1). This gives every destination position in each dimension: below, equal and above. It also puts zero, one and more credits within reach of random stimulus. One copy is a request network with multi-flit worms, so it exercises locking, stalled owners, tail release and the HOME reserve. The other is a single-flit response network, so it exercises pure rotation and the HOME exemption from credit. Directed sequences cover each routing direction and each lock transition, and a long random sweep compares both copies every cycle against an arithmetic model of pointers, locks and credit rules.

// File: rtl/wh_alloc_pkg.sv
package wh_alloc_pkg;
  localparam int NPORT  = 5;
  localparam int PIDX_W = $clog2(NPORT);

  typedef enum logic [2:0] {
    P_HOME  = 3'd0,
    P_UP    = 3'd1,
    P_DOWN  = 3'd2,
    P_LEFT  = 3'd3,
    P_RIGHT = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    FL_HEAD = 2'd0,
    FL_BODY = 2'd1,
    FL_TAIL = 2'd2,
    FL_RSVD = 2'd3
  } flit_e;

  localparam int NET_GENERIC  = 0;
  localparam int NET_REQUEST  = 1;
  localparam int NET_RESPONSE = 2;
endpackage

// File: rtl/wh_route_calc.sv
module wh_route_calc
  import wh_alloc_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [NPORT-1:0]   dir_oh
);
  // X first, then Y, HOME when both coordinates match (R2, R3)
  always_comb begin
    dir_oh = '0;
    if (dst_x < here_x)      dir_oh[int'(P_LEFT)]  = 1'b1;
    else if (dst_x > here_x) dir_oh[int'(P_RIGHT)] = 1'b1;
    else if (dst_y < here_y) dir_oh[int'(P_UP)]    = 1'b1;
    else if (dst_y > here_y) dir_oh[int'(P_DOWN)]  = 1'b1;
    else                     dir_oh[int'(P_HOME)]  = 1'b1;
  end
endmodule

// File: rtl/wh_rr_pick.sv
module wh_rr_pick #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] pick
);
  // Scan from the farthest offset to the nearest, so the nearest requester wins (R4)
  always_comb begin
    hit  = 1'b0;
    pick = last;
    for (int k = N; k >= 1; k--) begin
      if (req[(int'(last) + k) % N]) begin
        hit  = 1'b1;
        pick = IW'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/wh_out_port.sv
module wh_out_port #(
  parameter int N          = 5,
  parameter int IW         = 3,
  parameter int CREDIT_W   = 3,
  parameter int MIN_CREDIT = 1,
  parameter bit ALWAYS_OK  = 1'b0,
  parameter bit MULTI_FLIT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        req,
  input  logic [N-1:0]        flit_ok,
  input  logic [N-1:0]        flit_tail,
  input  logic [CREDIT_W-1:0] credit,
  output logic [N-1:0]        gnt_q,
  output logic                lock_q,
  output logic [IW-1:0]       owner_q
);
  logic [IW-1:0] ptr_q, ptr_d, owner_d, pick;
  logic [N-1:0]  gnt_d;
  logic          lock_d, elig, hit;

  generate
    if (ALWAYS_OK) begin : g_free
      assign elig = 1'b1;
    end else begin : g_credit
      assign elig = (credit >= CREDIT_W'(MIN_CREDIT));
    end
  endgenerate

  wh_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req  (req),
    .last (ptr_q),
    .hit  (hit),
    .pick (pick)
  );

  always_comb begin
    gnt_d   = '0;
    lock_d  = lock_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    if (elig) begin
      if (lock_q) begin
        if (flit_ok[owner_q]) begin
          gnt_d[owner_q] = 1'b1;
          ptr_d          = owner_q;
          if (flit_tail[owner_q]) lock_d = 1'b0;
        end
      end else if (hit) begin
        gnt_d[pick] = 1'b1;
        ptr_d       = pick;
        if (MULTI_FLIT) begin
          lock_d  = 1'b1;
          owner_d = pick;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= '0;
      lock_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= IW'(N - 1);
    end else begin
      gnt_q   <= gnt_d;
      lock_q  <= lock_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
    end
  end
endmodule

// File: rtl/wh_switch_alloc.sv
module wh_switch_alloc
  import wh_alloc_pkg::*;
#(
  parameter int COORD_W    = 3,
  parameter int CREDIT_W   = 3,
  parameter bit MULTI_FLIT = 1'b1,
  parameter int NET_KIND   = NET_REQUEST
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [COORD_W-1:0]        here_x,
  input  logic [COORD_W-1:0]        here_y,
  input  logic [NPORT-1:0]          in_valid,
  input  logic [2*NPORT-1:0]        in_type,
  input  logic [NPORT*COORD_W-1:0]  in_dst_x,
  input  logic [NPORT*COORD_W-1:0]  in_dst_y,
  input  logic [NPORT*CREDIT_W-1:0] out_credit,
  output logic [NPORT*NPORT-1:0]    grant
);
  logic [NPORT-1:0]        route_oh [NPORT];
  logic [NPORT-1:0]        req_to   [NPORT];
  logic [NPORT-1:0]        is_head, is_tail, busy, lock_vec;
  logic [NPORT*PIDX_W-1:0] owner_flat;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    wh_route_calc #(.COORD_W(COORD_W)) u_route (
      .here_x (here_x),
      .here_y (here_y),
      .dst_x  (in_dst_x[i*COORD_W +: COORD_W]),
      .dst_y  (in_dst_y[i*COORD_W +: COORD_W]),
      .dir_oh (route_oh[i])
    );
    assign is_head[i] = (in_type[2*i +: 2] == FL_HEAD);
    assign is_tail[i] = (in_type[2*i +: 2] == FL_TAIL);
  end

  // An input in the middle of a worm may not start a second one elsewhere (R6)
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      busy[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        if (lock_vec[o] && owner_flat[o*PIDX_W +: PIDX_W] == PIDX_W'(i)) busy[i] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req_to[o][i] = in_valid[i] & is_head[i] & route_oh[i][o] & ~busy[i];
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    localparam int MINC = (NET_KIND == NET_REQUEST && o == int'(P_HOME)) ? 2 : 1;
    localparam bit AOK  = (NET_KIND == NET_RESPONSE && o == int'(P_HOME));
    wh_out_port #(
      .N          (NPORT),
      .IW         (PIDX_W),
      .CREDIT_W   (CREDIT_W),
      .MIN_CREDIT (MINC),
      .ALWAYS_OK  (AOK),
      .MULTI_FLIT (MULTI_FLIT)
    ) u_port (
      .clk       (clk),
      .rst       (rst),
      .req       (req_to[o]),
      .flit_ok   (in_valid),
      .flit_tail (is_tail),
      .credit    (out_credit[o*CREDIT_W +: CREDIT_W]),
      .gnt_q     (grant[o*NPORT +: NPORT]),
      .lock_q    (lock_vec[o]),
      .owner_q   (owner_flat[o*PIDX_W +: PIDX_W])
    );
  end
endmodule

// File: rtl/wh_alloc_checker.sv
module wh_alloc_checker #(
  parameter int NP       = 5,
  parameter int IW       = 3,
  parameter int CREDIT_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NP-1:0]          in_valid,
  input logic [2*NP-1:0]        in_type,
  input logic [NP*CREDIT_W-1:0] out_credit,
  input logic [NP*NP-1:0]       grant,
  input logic [NP-1:0]          lock_vec,
  input logic [NP*IW-1:0]       owner_flat
);
  logic [NP-1:0] col    [NP];
  logic [NP-1:0] own_oh [NP];

  always_comb begin
    for (int i = 0; i < NP; i++)
      for (int o = 0; o < NP; o++) col[i][o] = grant[o*NP + i];
    for (int o = 0; o < NP; o++) begin
      own_oh[o] = '0;
      own_oh[o][owner_flat[o*IW +: IW]] = 1'b1;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (grant == '0 && lock_vec == '0));

  for (genvar o = 0; o < NP; o++) begin : g_o
    assert_onehot_slice_R12: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant[o*NP +: NP]));

    assert_lock_forward_R6: assert property (@(posedge clk) disable iff (rst)
      (lock_vec[o] && in_valid[owner_flat[o*IW +: IW]] &&
       out_credit[o*CREDIT_W +: CREDIT_W] >= 2)
      |=> grant[o*NP +: NP] == $past(own_oh[o]));

    assert_tail_release_R7: assert property (@(posedge clk) disable iff (rst)
      (lock_vec[o] && in_valid[owner_flat[o*IW +: IW]] &&
       in_type[2*owner_flat[o*IW +: IW] +: 2] == 2'd2 &&
       out_credit[o*CREDIT_W +: CREDIT_W] >= 2)
      |=> !lock_vec[o]);

    assert_stalled_owner_R11: assert property (@(posedge clk) disable iff (rst)
      (lock_vec[o] && !in_valid[owner_flat[o*IW +: IW]])
      |=> (lock_vec[o] && grant[o*NP +: NP] == '0 && $stable(owner_flat[o*IW +: IW])));

    if (o != 0) begin : g_cr
      assert_no_credit_R8: assert property (@(posedge clk) disable iff (rst)
        (out_credit[o*CREDIT_W +: CREDIT_W] == '0) |=> grant[o*NP +: NP] == '0);
    end

    for (genvar i = 0; i < NP; i++) begin : g_i
      assert_head_only_R5: assert property (@(posedge clk) disable iff (rst)
        (!lock_vec[o] && in_type[2*i +: 2] != 2'd0) |=> !grant[o*NP + i]);
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_col
    assert_one_output_per_input_R12: assert property (@(posedge clk) disable iff (rst)
      $countones(col[i]) <= 1);
  end
endmodule

bind wh_switch_alloc wh_alloc_checker #(
  .NP       (5),
  .IW       (3),
  .CREDIT_W (CREDIT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_type    (in_type),
  .out_credit (out_credit),
  .grant      (grant),
  .lock_vec   (lock_vec),
  .owner_flat (owner_flat)
);

// File: tb/wh_switch_alloc_test.sv
`timescale 1ns/1ps
module wh_switch_alloc_test;
  localparam int CW = 2;
  localparam int KW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] here_x = 2'd1, here_y = 2'd1;
  logic [4:0]    in_valid = '0;
  logic [9:0]    in_type = '0;
  logic [5*CW-1:0] in_dst_x = '0, in_dst_y = '0;
  logic [5*KW-1:0] out_credit = '0;
  logic [24:0]   grant, grant_rsp;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int   m_ptr  [2][5];
  int   m_own  [2][5];
  bit   m_lock [2][5];
  logic [24:0] exp_g [2];

  always #10 clk = ~clk;

  wh_switch_alloc #(.COORD_W(CW), .CREDIT_W(KW), .MULTI_FLIT(1'b1), .NET_KIND(1)) uut (
    .clk(clk), .rst(rst), .here_x(here_x), .here_y(here_y), .in_valid(in_valid),
    .in_type(in_type), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .out_credit(out_credit), .grant(grant));

  wh_switch_alloc #(.COORD_W(CW), .CREDIT_W(KW), .MULTI_FLIT(1'b0), .NET_KIND(2)) uut_rsp (
    .clk(clk), .rst(rst), .here_x(here_x), .here_y(here_y), .in_valid(in_valid),
    .in_type(in_type), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .out_credit(out_credit), .grant(grant_rsp));

  function automatic int route_of(int dx, int dy);
    if (dx < 1) return 3;
    if (dx > 1) return 4;
    if (dy < 1) return 1;
    if (dy > 1) return 2;
    return 0;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++)
      for (int o = 0; o < 5; o++) begin
        m_ptr[k][o] = 4; m_own[k][o] = 0; m_lock[k][o] = 1'b0;
      end
  endtask

  // k=0: request network, multi-flit; k=1: response network, single-flit
  task automatic model_step(int k);
    logic [4:0]  busy;
    logic [24:0] g;
    busy = '0;
    g    = '0;
    for (int o = 0; o < 5; o++) if (m_lock[k][o]) busy[m_own[k][o]] = 1'b1;
    for (int o = 0; o < 5; o++) begin
      int cr;
      bit el;
      cr = int'(out_credit[o*KW +: KW]);
      if (o == 0) el = (k == 0) ? (cr >= 2) : 1'b1;
      else        el = (cr >= 1);
      if (!el) continue;
      if (m_lock[k][o]) begin
        int w;
        w = m_own[k][o];
        if (in_valid[w]) begin
          g[o*5 + w] = 1'b1;
          m_ptr[k][o] = w;
          if (in_type[2*w +: 2] == 2'd2) m_lock[k][o] = 1'b0;
        end
      end else begin
        for (int off = 1; off <= 5; off++) begin
          int c;
          c = (m_ptr[k][o] + off) % 5;
          if (in_valid[c] && in_type[2*c +: 2] == 2'd0 && !busy[c] &&
              route_of(int'(in_dst_x[c*CW +: CW]), int'(in_dst_y[c*CW +: CW])) == o) begin
            g[o*5 + c] = 1'b1;
            m_ptr[k][o] = c;
            if (k == 0) begin m_lock[k][o] = 1'b1; m_own[k][o] = c; end
            break;
          end
        end
      end
    end
    exp_g[k] = g;
  endtask

  task automatic compare(string tag, string who, logic [24:0] got, logic [24:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, who, got, exp);
    end
  endtask

  // called at a negedge with inputs already driven
  task automatic cycle(string tag);
    model_step(0);
    model_step(1);
    @(negedge clk);
    compare(tag, "uut", grant, exp_g[0]);
    compare(tag, "uut_rsp", grant_rsp, exp_g[1]);
  endtask

  task automatic drive(int i, bit v, int t, int dx, int dy);
    in_valid[i]          = v;
    in_type[2*i +: 2]    = 2'(t);
    in_dst_x[i*CW +: CW] = CW'(dx);
    in_dst_y[i*CW +: CW] = CW'(dy);
  endtask

  task automatic all_credit(int c);
    for (int o = 0; o < 5; o++) out_credit[o*KW +: KW] = KW'(c);
  endtask

  task automatic clear_inputs();
    for (int i = 0; i < 5; i++) drive(i, 1'b0, 0, 1, 1);
  endtask

  // one single-flit worm on input i, literal check of response copy, then tail
  task automatic route_case(string tag, int i, int dx, int dy, int out_idx);
    drive(i, 1'b1, 0, dx, dy);
    cycle(tag);
    compare(tag, "uut_rsp literal", grant_rsp, 25'(1) << (out_idx*5 + i));
    drive(i, 1'b1, 2, dx, dy);
    cycle("R7");
    compare("R5", "uut_rsp tail ignored", grant_rsp, '0);
    drive(i, 1'b0, 0, 1, 1);
  endtask

  initial begin
    model_reset();
    all_credit(3);
    repeat (3) @(negedge clk);
    compare("R1", "uut reset", grant, '0);
    compare("R1", "uut_rsp reset", grant_rsp, '0);
    rst = 1'b0;
    cycle("R1");
    cycle("R13");

    // routing in every direction (R2, R3)
    route_case("R2", 0, 0, 1, 3);
    route_case("R2", 1, 2, 1, 4);
    route_case("R3", 2, 1, 0, 1);
    route_case("R3", 3, 1, 2, 2);
    route_case("R3", 4, 1, 1, 0);

    // all inputs contend for RIGHT: rotation (R4), worm ownership in uut (R6)
    for (int i = 0; i < 5; i++) drive(i, 1'b1, 0, 2, 0);
    repeat (6) cycle("R4");
    clear_inputs();
    cycle("R13");
    // release uut RIGHT lock: owner sends its tail
    for (int i = 0; i < 5; i++) begin
      drive(i, 1'b1, 2, 2, 0);
      cycle("R7");
      drive(i, 1'b0, 0, 1, 1);
    end
    cycle("R13");

    // non-head flits on idle outputs (R5)
    for (int i = 0; i < 5; i++) drive(i, 1'b1, 1 + (i % 3), 0, 0);
    cycle("R5");
    compare("R5", "uut no start", grant, '0);
    clear_inputs();

    // zero credit on RIGHT (R8)
    out_credit[4*KW +: KW] = '0;
    drive(2, 1'b1, 0, 3, 1);
    repeat (2) cycle("R8");
    compare("R8", "uut_rsp starved", grant_rsp, '0);
    all_credit(3);
    cycle("R8");
    drive(2, 1'b1, 2, 3, 1);
    cycle("R7");
    clear_inputs();

    // HOME reserve on request network, free on response network (R9)
    out_credit[0 +: KW] = 2'd1;
    drive(3, 1'b1, 0, 1, 1);
    cycle("R9");
    compare("R9", "uut home reserve", grant, '0);
    compare("R9", "uut_rsp home free", grant_rsp, 25'(1) << 3);
    out_credit[0 +: KW] = 2'd0;
    cycle("R9");
    out_credit[0 +: KW] = 2'd2;
    cycle("R9");
    drive(3, 1'b1, 2, 1, 1);
    cycle("R7");
    clear_inputs();
    all_credit(3);

    // worm on LEFT: stall (R11), forward body regardless of route (R6), tail (R7)
    drive(4, 1'b1, 0, 0, 2);
    cycle("R6");
    drive(4, 1'b0, 1, 0, 2);
    drive(0, 1'b1, 0, 0, 0);
    cycle("R11");
    compare("R11", "uut stalled", grant[15 +: 5], '0);
    drive(4, 1'b1, 1, 3, 3);
    cycle("R6");
    compare("R6", "uut body forwarded", grant[15 +: 5], 5'b10000);
    out_credit[3*KW +: KW] = '0;
    drive(4, 1'b1, 2, 3, 3);
    cycle("R8");
    out_credit[3*KW +: KW] = 2'd3;
    cycle("R7");
    drive(4, 1'b0, 0, 1, 1);
    cycle("R7");
    compare("R7", "uut next worm", grant[15 +: 5], 5'b00001);

    // single-flit copy: head then body from same input (R10)
    clear_inputs();
    drive(1, 1'b1, 0, 2, 2);
    cycle("R10");
    drive(1, 1'b1, 1, 2, 2);
    cycle("R10");
    compare("R10", "uut_rsp body ignored", grant_rsp, '0);
    drive(1, 1'b1, 2, 2, 2);
    cycle("R7");
    clear_inputs();
    cycle("R13");

    // random sweep (R12)
    void'($urandom(32'd7));
    for (int n = 0; n < 4000; n++) begin
      in_valid   = 5'($urandom);
      in_type    = 10'($urandom);
      in_dst_x   = (5*CW)'($urandom);
      in_dst_y   = (5*CW)'($urandom);
      out_credit = (5*KW)'($urandom);
      cycle("R12");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule